// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block is a bank of wide event counters for on-chip performance measurement. Each counter watches one of a set of per-cycle event pulses. The event sources are grouped as four ports with six sources each. A small control word per counter picks the source with a five-bit code and holds two enables: one for counting and one for the overflow interrupt.

Software sets up the block through a plain write interface. It can preload any counter and can read any counter at any moment, including while it counts. To stop after N events, software loads the counter with 2^48 − N and sets its interrupt enable. When the counter carries out of its top bit, the block pulses an interrupt request toward a global controller. That controller later drops the shared global enable and freezes every counter. Until that happens, the counter that overflowed wraps through zero and keeps counting, so the full event total can still be recovered.

A sticky per-counter overflow flag records every wrap. Software clears it by writing a one.

Top module: `evt_ctr_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter reads 0, every control word is cleared (counting disabled, interrupt disabled, code 0), and all interrupt and overflow-flag outputs are 0.
- R2: A counter increments by exactly one on a cycle only when its local enable is set, `glb_en` is high and its selected event pulse is high. Otherwise it holds its value.
- R3: Select code c in 0..23 picks `evt_in[c]`, where c = port*6 + source. Port numbers run 0..3. Within a port the source order is: performance event 0, performance event 1, link event 0, link event 1, crossbar match set 1, crossbar match set 2.
- R4: Select codes 24..31 pick no event, so a counter with such a code never increments, even when every event input is high.
- R5: An increment of a counter holding 2^48−1 wraps it to 0, and counting continues from there. If the counter's interrupt enable was set when the wrap happened, `ovf_irq` for that counter is high for exactly one cycle. That cycle is the first one in which the wrapped value 0 is visible. With the interrupt enable clear, the interrupt output never rises.
- R6: `ovf_sts` for a counter is set by every wrap, whatever the interrupt enable. It stays set until a one on the matching `ovf_clr` bit clears it. A wrap in the same cycle as a clear leaves it set.
- R7: A preload write to a counter takes priority over an increment in the same cycle. The written value appears on the next cycle, with no increment added.
- R8: `rd_data` shows the current value of the counter chosen by `rd_idx`, with no added latency. Reading has no effect on counting.
- R9: While `glb_en` is low, no counter changes except through a preload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 24 | Per-cycle event pulses, bit index = port*6 + source |
| glb_en | input | 1 | Global count enable from the global controller |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 2 | Counter addressed by the control write |
| cfg_en | input | 1 | Local count enable value to write |
| cfg_ie | input | 1 | Overflow interrupt enable value to write |
| cfg_code | input | 5 | Event select code to write |
| cnt_we | input | 1 | Counter preload write strobe |
| cnt_idx | input | 2 | Counter addressed by the preload |
| cnt_wdata | input | 48 | Preload value |
| ovf_clr | input | 4 | Write-one-to-clear for the overflow flags |
| rd_idx | input | 2 | Counter shown on rd_data |
| rd_data | output | 48 | Current value of the selected counter |
| ovf_irq | output | 4 | One-cycle overflow interrupt request per counter |
| ovf_sts | output | 4 | Sticky overflow flag per counter |

## Verification
The bench builds the block with its default parameters: four counters of 48 bits, fed by four ports of six sources each. Preloading values just below 2^48 brings the carry out of bit 47, the wrap and the one-cycle interrupt within a handful of cycles. This covers both settings of the interrupt enable, a wrap that coincides with a flag clear, and the freeze caused by dropping the global enable after a wrap. All 24 legal codes and all eight illegal codes are swept on one counter, which exposes any error in the port-by-source ordering.

// File: rtl/perfctr_pkg.sv
// Shared types for the performance counter bank.
// Assumes a five-bit event select code for every counter.
package perfctr_pkg;

    localparam int SEL_W = 5;

    // Per-counter control word held by each slice
    typedef struct packed {
        logic             en;   // local count enable
        logic             ie;   // interrupt on overflow enable
        logic [SEL_W-1:0] code; // event select code
    } ctr_cfg_t;

endpackage

// File: rtl/evt_sel_mux.sv
// Event selector: maps a select code onto one pulse out of NUM_PORT*SRC_PER_PORT.
// Code = port*SRC_PER_PORT + source. Codes at or above the event count select nothing.
// Assumes NUM_PORT*SRC_PER_PORT fits in the code width.
module evt_sel_mux #(
    parameter int NUM_PORT     = 4,
    parameter int SRC_PER_PORT = 6,
    parameter int SEL_W        = 5,
    localparam int NUM_EVT     = NUM_PORT * SRC_PER_PORT
) (
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [SEL_W-1:0]   code,
    output logic               hit
);

    // Group the flat event vector by port for readability of the decode
    logic [SRC_PER_PORT-1:0] port_evt [NUM_PORT];

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        assign port_evt[p] = evt_in[p*SRC_PER_PORT +: SRC_PER_PORT];
    end

    // Decode port and source from the code; an illegal code leaves hit low
    always_comb begin
        hit = 1'b0;
        for (int p = 0; p < NUM_PORT; p++) begin
            for (int s = 0; s < SRC_PER_PORT; s++) begin
                if (code == SEL_W'(p*SRC_PER_PORT + s)) begin
                    hit = port_evt[p][s];
                end
            end
        end
    end

    // The decode needs every legal code to fit in the code width
    initial begin
        AST_SEL_FITS: assert (NUM_EVT <= (1 << SEL_W)); // R4
    end

endmodule

// File: rtl/ctr_slice.sv
// One counter: control word, wide count register, overflow interrupt and sticky flag.
// Assumes event pulses are sampled once per cycle. A preload beats an increment.
// The interrupt is registered, so it is seen together with the wrapped value.
module ctr_slice
    import perfctr_pkg::*;
#(
    parameter int CTR_W        = 48,
    parameter int NUM_PORT     = 4,
    parameter int SRC_PER_PORT = 6,
    localparam int NUM_EVT     = NUM_PORT * SRC_PER_PORT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               cfg_we,
    input  ctr_cfg_t           cfg_wdata,
    input  logic               cnt_we,
    input  logic [CTR_W-1:0]   cnt_wdata,
    input  logic               ovf_clr,
    output logic [CTR_W-1:0]   cnt_q,
    output logic               ovf_irq,
    output logic               ovf_sts
);

    ctr_cfg_t         cfg_q;
    logic             evt_hit;
    logic             step;
    logic             carry;
    logic [CTR_W-1:0] cnt_inc;
    logic             wrap;

    evt_sel_mux #(
        .NUM_PORT     (NUM_PORT),
        .SRC_PER_PORT (SRC_PER_PORT),
        .SEL_W        (SEL_W)
    ) u_sel (
        .evt_in (evt_in),
        .code   (cfg_q.code),
        .hit    (evt_hit)
    );

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Increment value, carry out of the top bit, and the qualified count step
    always_comb begin
        {carry, cnt_inc} = {1'b0, cnt_q} + {{CTR_W{1'b0}}, 1'b1};
        step             = cfg_q.en & glb_en & evt_hit;
        wrap             = step & ~cnt_we & carry;
    end

    // Count register: preload first, then increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end else if (step) begin
            cnt_q <= cnt_inc;
        end
    end

    // One-cycle interrupt request on a wrap with the interrupt enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_irq <= 1'b0;
        end else begin
            ovf_irq <= wrap & cfg_q.ie;
        end
    end

    // Sticky overflow flag, a wrap outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_sts <= 1'b0;
        end else if (wrap) begin
            ovf_sts <= 1'b1;
        end else if (ovf_clr) begin
            ovf_sts <= 1'b0;
        end
    end

    AST_NO_COUNT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !(cfg_q.en && glb_en)) |=> $stable(cnt_q)); // R2

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_ILLEGAL_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && cfg_q.code >= SEL_W'(NUM_EVT)) |=> $stable(cnt_q)); // R4

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (cnt_q == '0)); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq); // R5

    AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_sts); // R6

    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(cnt_wdata))); // R7

    AST_FROZEN_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cnt_we) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/evt_ctr_bank.sv
// Bank of event-selectable counters that share one global enable.
// Routes control writes, preloads and flag clears to each slice and muxes the read port.
// Assumes NUM_CTR is at least two; an index past the last counter reads zero.
module evt_ctr_bank
    import perfctr_pkg::*;
#(
    parameter int NUM_CTR      = 4,
    parameter int CTR_W        = 48,
    parameter int NUM_PORT     = 4,
    parameter int SRC_PER_PORT = 6,
    localparam int NUM_EVT     = NUM_PORT * SRC_PER_PORT,
    localparam int IDX_W       = $clog2(NUM_CTR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               glb_en,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_en,
    input  logic               cfg_ie,
    input  logic [SEL_W-1:0]   cfg_code,
    input  logic               cnt_we,
    input  logic [IDX_W-1:0]   cnt_idx,
    input  logic [CTR_W-1:0]   cnt_wdata,
    input  logic [NUM_CTR-1:0] ovf_clr,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CTR_W-1:0]   rd_data,
    output logic [NUM_CTR-1:0] ovf_irq,
    output logic [NUM_CTR-1:0] ovf_sts
);

    ctr_cfg_t         cfg_word;
    logic [CTR_W-1:0] cnt_all [NUM_CTR];

    // Pack the control write fields into the shared control type
    always_comb begin
        cfg_word.en   = cfg_en;
        cfg_word.ie   = cfg_ie;
        cfg_word.code = cfg_code;
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        ctr_slice #(
            .CTR_W        (CTR_W),
            .NUM_PORT     (NUM_PORT),
            .SRC_PER_PORT (SRC_PER_PORT)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .glb_en    (glb_en),
            .evt_in    (evt_in),
            .cfg_we    (cfg_we && (cfg_idx == IDX_W'(i))),
            .cfg_wdata (cfg_word),
            .cnt_we    (cnt_we && (cnt_idx == IDX_W'(i))),
            .cnt_wdata (cnt_wdata),
            .ovf_clr   (ovf_clr[i]),
            .cnt_q     (cnt_all[i]),
            .ovf_irq   (ovf_irq[i]),
            .ovf_sts   (ovf_sts[i])
        );
    end

    // Read port: current value of the addressed counter
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = cnt_all[i];
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (ovf_irq == '0) && (ovf_sts == '0) && (rd_data == '0)); // R1

endmodule

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;

    localparam int        NC   = 4;
    localparam int        W    = 48;
    localparam int        NE   = 24;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NE-1:0] evt_in;
    logic          glb_en;
    logic          cfg_we;
    logic [1:0]    cfg_idx;
    logic          cfg_en;
    logic          cfg_ie;
    logic [4:0]    cfg_code;
    logic          cnt_we;
    logic [1:0]    cnt_idx;
    logic [W-1:0]  cnt_wdata;
    logic [NC-1:0] ovf_clr;
    logic [1:0]    rd_idx;
    logic [W-1:0]  rd_data;
    logic [NC-1:0] ovf_irq;
    logic [NC-1:0] ovf_sts;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    evt_ctr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .glb_en(glb_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_ie(cfg_ie),
        .cfg_code(cfg_code), .cnt_we(cnt_we), .cnt_idx(cnt_idx),
        .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .rd_idx(rd_idx),
        .rd_data(rd_data), .ovf_irq(ovf_irq), .ovf_sts(ovf_sts)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input int idx, output logic [W-1:0] v);
        rd_idx = 2'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic cfg(input int idx, input logic en, input logic ie, input int code);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_ie = ie; cfg_code = 5'(code);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic load(input int idx, input logic [W-1:0] v);
        cnt_we = 1'b1; cnt_idx = 2'(idx); cnt_wdata = v;
        tick();
        cnt_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rst_n = 1'b0; evt_in = '1; glb_en = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        for (int i = 0; i < NC; i++) begin
            rd(i, v);
            chk($sformatf("R1 counter %0d after reset", i), 64'(v), 64'd0);
        end
        chk("R1 irq after reset", 64'(ovf_irq), 64'd0);
        chk("R1 flags after reset", 64'(ovf_sts), 64'd0);
        repeat (2) tick();
        rd(0, v);
        chk("R1 control disabled after reset", 64'(v), 64'd0);
        evt_in = '0;
    endtask

    task automatic t_select();
        logic [W-1:0] v;
        for (int c = 0; c < NE; c++) begin
            cfg(0, 1'b1, 1'b0, c);
            load(0, '0);
            evt_in = NE'(1) << c;
            repeat (3) tick();
            evt_in = ~(NE'(1) << c);
            repeat (2) tick();
            evt_in = '0;
            rd(0, v);
            chk($sformatf("R3 code %0d port %0d source %0d", c, c / 6, c % 6), 64'(v), 64'd3);
        end
    endtask

    task automatic t_illegal();
        logic [W-1:0] v;
        for (int c = NE; c < 32; c++) begin
            cfg(1, 1'b1, 1'b1, c);
            load(1, 48'd5);
            evt_in = '1;
            repeat (4) tick();
            evt_in = '0;
            rd(1, v);
            chk($sformatf("R4 illegal code %0d", c), 64'(v), 64'd5);
        end
    endtask

    task automatic t_gating();
        logic [W-1:0] v;
        cfg(1, 1'b1, 1'b0, 0);
        load(1, 48'd10);
        glb_en = 1'b0; evt_in = 24'h1;
        repeat (2) tick();
        rd(1, v);
        chk("R9 global enable low holds", 64'(v), 64'd10);
        glb_en = 1'b1; evt_in = '0;
        repeat (2) tick();
        rd(1, v);
        chk("R2 no event holds", 64'(v), 64'd10);
        cfg(1, 1'b0, 1'b0, 0);
        evt_in = 24'h1;
        repeat (2) tick();
        rd(1, v);
        chk("R2 local enable low holds", 64'(v), 64'd10);
        evt_in = '0;
        cfg(1, 1'b1, 1'b0, 0);
        evt_in = 24'h1;
        repeat (2) tick();
        evt_in = '0;
        rd(1, v);
        chk("R2 all enables high counts", 64'(v), 64'd12);
    endtask

    task automatic t_priority();
        logic [W-1:0] v;
        cfg(2, 1'b1, 1'b0, 1);
        evt_in = 24'h2;
        load(2, 48'd100);
        rd(2, v);
        chk("R7 preload beats increment", 64'(v), 64'd100);
        tick();
        rd(2, v);
        chk("R7 counting resumes after preload", 64'(v), 64'd101);
        evt_in = '0;
    endtask

    task automatic t_wrap_irq();
        logic [W-1:0] v;
        ovf_clr = '1; tick(); ovf_clr = '0;
        cfg(3, 1'b1, 1'b1, 5);
        load(3, MAXV - 48'd2);
        evt_in = 24'h20;
        tick();
        chk("R5 no irq before wrap", 64'(ovf_irq[3]), 64'd0);
        tick();
        chk("R5 no irq at max", 64'(ovf_irq[3]), 64'd0);
        tick();
        rd(3, v);
        chk("R5 wrapped to zero", 64'(v), 64'd0);
        chk("R5 irq with wrapped value", 64'(ovf_irq[3]), 64'd1);
        chk("R6 flag set by wrap", 64'(ovf_sts[3]), 64'd1);
        tick();
        rd(3, v);
        chk("R5 counting continues after wrap", 64'(v), 64'd1);
        chk("R5 irq lasts one cycle", 64'(ovf_irq[3]), 64'd0);
        glb_en = 1'b0;
        repeat (3) tick();
        rd(3, v);
        chk("R9 freeze after global disable", 64'(v), 64'd1);
        chk("R6 flag stays set", 64'(ovf_sts[3]), 64'd1);
        glb_en = 1'b1; evt_in = '0;
    endtask

    task automatic t_wrap_noirq();
        logic [W-1:0] v;
        int irq_seen = 0;
        cfg(0, 1'b1, 1'b0, 2);
        load(0, MAXV);
        evt_in = 24'h4;
        tick();
        if (ovf_irq[0]) irq_seen++;
        evt_in = '0;
        rd(0, v);
        chk("R5 wrap without interrupt enable", 64'(v), 64'd0);
        tick();
        if (ovf_irq[0]) irq_seen++;
        chk("R5 irq stays low when disabled", 64'(irq_seen), 64'd0);
        chk("R6 flag set without interrupt enable", 64'(ovf_sts[0]), 64'd1);
        ovf_clr = 4'h1; tick(); ovf_clr = '0;
        chk("R6 write one clears flag", 64'(ovf_sts[0]), 64'd0);
        load(0, MAXV);
        evt_in = 24'h4; ovf_clr = 4'h1;
        tick();
        evt_in = '0; ovf_clr = '0;
        chk("R6 wrap outranks clear", 64'(ovf_sts[0]), 64'd1);
    endtask

    task automatic t_read_live();
        logic [W-1:0] v;
        cfg(1, 1'b1, 1'b0, 3);
        load(1, '0);
        evt_in = 24'h8;
        for (int i = 1; i <= 5; i++) begin
            tick();
            rd(1, v);
            chk($sformatf("R8 live read step %0d", i), 64'(v), 64'(i));
        end
        evt_in = '0;
    endtask

    initial begin
        rst_n = 1'b0; evt_in = '0; glb_en = 1'b1;
        cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0; cfg_ie = 1'b0; cfg_code = '0;
        cnt_we = 1'b0; cnt_idx = '0; cnt_wdata = '0; ovf_clr = '0; rd_idx = '0;
        tick();
        t_reset();
        t_select();
        t_illegal();
        t_gating();
        t_priority();
        t_wrap_irq();
        t_wrap_noirq();
        t_read_live();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule